// File: doc/BRIEF.md
# Debugger Control Port Register Block

This block is a small register file that an external debugger reaches through its access-port bus. Unlike the other debug access ports of the chip, it is never gated by access protection, so a debugger can always reach it. Through it the debugger can hold the device in reset, start a full erase of flash and RAM, watch the erase progress, read the current protection state and identify the port.

Requests are word-indexed: one request per cycle with a valid strobe, a write flag, a word index and write data. A read returns its data one cycle later together with a response strobe. An erase request produces a one-cycle start pulse toward an external erase engine. That engine reports completion with a done pulse, which returns the block to ready.

Top module: `ctrl_port_regs`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `hold_reset`, `erase_start` and `rsp_valid` are 0, and the erase status reads ready.
- R2: A write to word index 0 loads bit 0 of the write data into the hold flag, which drives `hold_reset` from the next cycle. Index 0 reads the flag in bit 0 with all other bits 0. No other request changes the flag.
- R3: A write to word index 1 with data bit 0 = 1 while ready makes `erase_start` high for exactly one cycle, the cycle after the request. Busy becomes 1 in that same cycle.
- R4: A write to word index 1 with data bit 0 = 0 produces no start pulse and leaves the status unchanged.
- R5: Word index 2 reads the erase status in bit 0 (1 = busy, 0 = ready). Busy stays 1 until a cycle in which `erase_done` is 1, and reads 0 from the following cycle. A done pulse while ready has no effect.
- R6: An erase request made while busy is ignored: it produces no start pulse, and the status still returns to ready after the single done pulse.
- R7: Word index 3 reads the protection state in bit 0 (1 = protection off, 0 = protection on), as sampled from `prot_open` in the request cycle.
- R8: Word index 63 reads the constant 0x02880000.
- R9: Reads of index 1 and of unmapped indices return 0. Writes to indices 2, 3, 63 or unmapped indices change nothing that is visible.
- R10: Every register behaves the same whatever the value of `prot_open`.
- R11: A read request gives `rsp_valid` = 1 and its data on `rsp_rdata` in the next cycle. A write request gives `rsp_valid` = 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word index of the register |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | DATA_W | Read data |
| hold_reset | output | 1 | Holds the device in reset while 1 |
| erase_start | output | 1 | One-cycle pulse that starts a full erase |
| erase_done | input | 1 | Erase engine completion pulse |
| prot_open | input | 1 | 1 when access protection is off |

## Verification
A corrupted busy flag shows up in one of two ways. It can produce a start pulse that should not occur, one cycle after an erase request. It can also produce a wrong status value, one cycle after a status read. A corrupted hold flag shows on `hold_reset` in the very next cycle. A wrong read multiplexer shows on `rsp_rdata` one cycle after the faulty read. Because the bench compares every output against its model on every cycle, any such fault is reported within one cycle of the first stimulus that exposes it.

// File: rtl/ctrl_port_regs.sv
module ctrl_port_regs #(
  parameter int          ADDR_W   = 6,
  parameter int          DATA_W   = 32,
  parameter int          ID_INDEX = 63,
  parameter logic [31:0] ID_VALUE = 32'h0288_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              hold_reset,
  output logic              erase_start,
  input  logic              erase_done,
  input  logic              prot_open
);

  localparam logic [ADDR_W-1:0] IX_HOLD  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] IX_ERASE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] IX_STAT  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] IX_PROT  = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] IX_ID    = ADDR_W'(ID_INDEX);

  logic hold_q, busy_q, start_q;
  logic wr, rd, go;
  logic [DATA_W-1:0] rmux;

  assign wr = req_valid && req_write;
  assign rd = req_valid && !req_write;
  assign go = wr && (req_addr == IX_ERASE) && req_wdata[0] && !busy_q;

  always_comb begin
    rmux = '0;
    unique case (req_addr)
      IX_HOLD: rmux[0] = hold_q;
      IX_STAT: rmux[0] = busy_q;
      IX_PROT: rmux[0] = prot_open;
      IX_ID:   rmux = DATA_W'(ID_VALUE);
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q    <= 1'b0;
      busy_q    <= 1'b0;
      start_q   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      start_q   <= go;
      rsp_valid <= rd;
      if (rd) rsp_rdata <= rmux;
      if (wr && req_addr == IX_HOLD) hold_q <= req_wdata[0];
      if (go) busy_q <= 1'b1;
      else if (busy_q && erase_done) busy_q <= 1'b0;
    end
  end

  assign hold_reset  = hold_q;
  assign erase_start = start_q;

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |=> !erase_start); // R3
  AST_START_MARKS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |-> busy_q); // R3
  AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !erase_done |=> busy_q); // R5
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && erase_done |=> !busy_q); // R5
  AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |=> !erase_start); // R6
  AST_HOLD_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr && req_addr == IX_HOLD) |=> $stable(hold_reset)); // R2
  AST_NO_RSP_FOR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> !rsp_valid); // R11

endmodule

// File: tb/sim_ctrl_port_regs.sv
module sim_ctrl_port_regs;
  localparam int AW = 6;
  localparam int DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic rsp_valid, hold_reset, erase_start;
  logic [DW-1:0] rsp_rdata;
  logic erase_done = 1'b0, prot_open = 1'b0;

  int tests = 0, fails = 0;
  bit running = 0, finished = 0;

  ctrl_port_regs u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .hold_reset(hold_reset), .erase_start(erase_start),
    .erase_done(erase_done), .prot_open(prot_open));

  always #5 clk = ~clk;

  // behavioural reference model
  bit  m_hold, m_busy, m_start, m_rv;
  int  m_rdata;
  int  m_lastaddr;

  always @(posedge clk) begin
    bit do_start;
    if (!rst_n) begin
      m_hold = 0; m_busy = 0; m_start = 0; m_rv = 0; m_rdata = 0;
    end else begin
      do_start = 0;
      m_rv = req_valid && !req_write;
      if (m_rv) begin
        m_lastaddr = int'(req_addr);
        if (req_addr == 0) m_rdata = int'(m_hold);
        else if (req_addr == 2) m_rdata = int'(m_busy);
        else if (req_addr == 3) m_rdata = int'(prot_open);
        else if (req_addr == 63) m_rdata = 32'h0288_0000;
        else m_rdata = 0;
      end
      if (req_valid && req_write) begin
        if (req_addr == 0) m_hold = req_wdata[0];
        if (req_addr == 1 && req_wdata[0] && !m_busy) do_start = 1;
      end
      if (do_start) m_busy = 1;
      else if (m_busy && erase_done) m_busy = 0;
      m_start = do_start;
    end
  end

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string rd_tag(int a);
    case (a)
      0: return "R2";
      2: return "R5";
      3: return "R7_R10";
      63: return "R8";
      default: return "R9";
    endcase
  endfunction

  always @(negedge clk) if (running) begin
    check("R2 hold_reset", int'(hold_reset), int'(m_hold));
    check("R3 erase_start", int'(erase_start), int'(m_start));
    check("R11 rsp_valid", int'(rsp_valid), int'(m_rv));
    if (m_rv) check({rd_tag(m_lastaddr), " rsp_rdata"}, int'(rsp_rdata), m_rdata);
  end

  task automatic step(bit v, bit w, int a, int d);
    req_valid = v; req_write = w; req_addr = AW'(a); req_wdata = DW'(d);
    @(negedge clk); #1;
    req_valid = 0; req_write = 0;
  endtask
  task automatic wr(int a, int d); step(1, 1, a, d); endtask
  task automatic rd(int a);        step(1, 0, a, 0); endtask
  task automatic idle(int n);      for (int i = 0; i < n; i++) step(0, 0, 0, 0); endtask
  task automatic done_pulse();
    erase_done = 1; step(0, 0, 0, 0); erase_done = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 hold_reset in reset", int'(hold_reset), 0);
    check("R1 erase_start in reset", int'(erase_start), 0);
    check("R1 rsp_valid in reset", int'(rsp_valid), 0);
    #1 rst_n = 1;
    running = 1;
    @(negedge clk); #1;
    check("R1 hold_reset after reset", int'(hold_reset), 0);
    rd(2);                                    // R1 status ready
    // R2 hold register
    wr(0, 1); rd(0); wr(0, 32'hFFFF_FFFE); rd(0); wr(0, 3); rd(0);
    // R9 writes elsewhere do not touch hold
    wr(2, 0); wr(3, 0); wr(63, 0); wr(17, 0); rd(0); wr(0, 0);
    // R4 write of 0 to erase trigger
    wr(1, 0); rd(2);
    // R3 start, R5 busy until done
    wr(1, 1); rd(2); idle(3); rd(2);
    // R6 request while busy ignored
    wr(1, 1); wr(1, 32'hFFFF_FFFF); rd(2);
    done_pulse(); rd(2);
    // R5 done while idle ignored
    done_pulse(); rd(2);
    // back-to-back: start right after clear
    wr(1, 1); erase_done = 1; step(0, 0, 0, 0); erase_done = 0; wr(1, 1); rd(2); done_pulse(); rd(2);
    // R7 R10 protection state, both values, plus erase under either state
    prot_open = 0; rd(3); prot_open = 1; rd(3);
    wr(1, 1); rd(2); done_pulse(); wr(0, 1); rd(0); prot_open = 0; rd(0); wr(0, 0);
    // R8 identification, R9 reads of write-only and unmapped
    rd(63); rd(1); rd(4); rd(62); rd(32);
    // R9 writes to status/id cannot alter them
    wr(63, 0); rd(63); wr(2, 1); rd(2);
    // mixed traffic
    for (int i = 0; i < 3000; i++) begin
      int a;
      a = ($urandom % 4 == 0) ? 63 : int'($urandom % 6);
      prot_open = 1'($urandom);
      erase_done = ($urandom % 5 == 0);
      step(1'($urandom % 4 != 0), 1'($urandom), a, int'($urandom));
      erase_done = 0;
    end
    idle(2);
    finish_run();
  end
endmodule